// File: doc/BRIEF.md
# Doorbell Ring Mailbox

The mailbox couples a host processor and an embedded engine through two rings of 32-bit words, one per direction. The host sees four word registers on a small read/write port: a transmit window that appends to the host-to-engine ring, a receive window that takes the oldest word from the engine-to-host ring, its own status word and a read-only copy of the engine's status word. The engine side is a plain strobe port. It pops the host-to-engine ring, pushes into the engine-to-host ring, rings a doorbell toward the host, acknowledges the host's doorbell and declares itself ready.

Each status word holds free-running 8-bit read and write pointers and the ring depth in slots. Software therefore computes occupancy as the pointer difference modulo 256 and free space as depth minus that figure. Interrupts work as a handshake. A doorbell sets a pending bit, the host clears it by writing a 1, and an enable bit gates it onto the host interrupt line. A reset request from the host empties both rings and drops both ready flags. The engine then declares ready again, and the host leaves reset and sets its own ready bit.

The ring depth is a parameter from 1 to 255 slots (default 8).

Top module: `ring_mailbox`

## Requirements
- R1: Both status words use one layout. Bit 0 is interrupt enable, bit 1 interrupt pending, bit 2 doorbell (reads as 0), bit 3 ready, bit 4 reset, bit 5 sticky overflow, bits 7:6 read 0. Bits 15:8 hold the read pointer, bits 23:16 the write pointer and bits 31:24 the depth. The host status word is at offset 0x4 and describes the host-to-engine ring. The engine status word is at offset 0xC and describes the engine-to-host ring; its bit 0 reads 0 and its bit 4 mirrors the host reset bit.
- R2: A host write to offset 0x0 while the host-to-engine ring has space stores the word and advances the write pointer by one. The engine sees the words on `eng_rdata` in write order, and each `eng_pop` advances the read pointer by one.
- R3: Pointers are 8 bits and wrap from 255 to 0 whatever the depth. The filled count is (write pointer − read pointer) mod 256 and never exceeds the depth. `eng_rx_count` shows the filled count of the host-to-engine ring and `eng_tx_space` shows depth minus the filled count of the engine-to-host ring.
- R4: A host write to offset 0x0 while the ring is full is dropped and leaves the write pointer unchanged. It sets host status bit 5, which stays set until the host writes 1 to bit 5 or requests a reset.
- R5: A host read of offset 0x8 returns the oldest engine word on `host_rdata` one cycle later and advances the engine-to-host read pointer. When that ring is empty the read returns 0 and leaves the pointer unchanged.
- R6: `eng_doorbell` sets host status bit 1. A host status write with bit 1 = 1 clears it and one with bit 1 = 0 leaves it. A doorbell in the same cycle as the clearing write wins.
- R7: `host_irq` is high exactly when host status bits 0 and 1 are both 1.
- R8: A host status write with bit 2 = 1 sets the engine pending bit (engine status bit 1, output `eng_irq`). `eng_is_clr` clears it.
- R9: A host status write with bit 4 = 1 sets all four pointers to 0 and clears both ready bits and both overflow bits. The reset bit stays 1, and is shown on `eng_rst_req`, until the host writes it 0.
- R10: `eng_set_ready` sets engine status bit 3, and the host sets its own ready bit by writing bit 3. A reset request in the same cycle overrides both.
- R11: A host read at any offset other than 0x0, 0x4, 0x8 and 0xC returns 0, and a host write there changes nothing.
- R12: `eng_push` while the engine-to-host ring is full is dropped and sets engine status bit 5 until the next reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| host_irq | output | 1 | Host interrupt |
| eng_push | input | 1 | Engine appends `eng_wdata` to the engine-to-host ring |
| eng_wdata | input | 32 | Engine push data |
| eng_pop | input | 1 | Engine consumes the head of the host-to-engine ring |
| eng_rdata | output | 32 | Head of the host-to-engine ring |
| eng_doorbell | input | 1 | Engine raises host pending |
| eng_is_clr | input | 1 | Engine clears its pending bit |
| eng_set_ready | input | 1 | Engine declares ready |
| eng_rx_count | output | 8 | Words waiting for the engine |
| eng_tx_space | output | 8 | Free slots toward the host |
| eng_irq | output | 1 | Engine pending (host doorbell) |
| eng_rst_req | output | 1 | Host reset bit |

## Verification
The assertions assume the host never drives `host_wr` and `host_rd` in the same cycle. Under that assumption a window write and a reset request can never coincide, and a drop can be tied to an unchanged write pointer. They also assume each engine strobe is a single-cycle pulse. The stimulus issues every host access as a one-cycle task and drives each engine strobe for one cycle. The only deliberately simultaneous events are the two priority cases: doorbell against clear, and ready against reset.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 32;

  localparam logic [3:0] OFS_TXWIN = 4'h0;
  localparam logic [3:0] OFS_HSTAT = 4'h4;
  localparam logic [3:0] OFS_RXWIN = 4'h8;
  localparam logic [3:0] OFS_ESTAT = 4'hC;

  localparam int B_IE  = 0;
  localparam int B_PND = 1;
  localparam int B_DB  = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_OVF = 5;

  typedef struct packed {
    logic ie;
    logic pend;
    logic rdy;
    logic rst;
    logic ovf;
  } side_flags_t;

  function automatic logic [PTR_W-1:0] slots_used(input logic [PTR_W-1:0] wp,
                                                  input logic [PTR_W-1:0] rp);
    return wp - rp;
  endfunction

  function automatic logic [PTR_W-1:0] slots_free(input logic [PTR_W-1:0] depth,
                                                  input logic [PTR_W-1:0] wp,
                                                  input logic [PTR_W-1:0] rp);
    return depth - slots_used(wp, rp);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input side_flags_t f,
                                                    input logic [PTR_W-1:0] rp,
                                                    input logic [PTR_W-1:0] wp,
                                                    input logic [PTR_W-1:0] depth);
    return {depth, wp, rp, 2'b00, f.ovf, f.rst, f.rdy, 1'b0, f.pend, f.ie};
  endfunction
endpackage

// File: rtl/mbox_ring.sv
`timescale 1ns/1ps
module mbox_ring
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [PTR_W-1:0] wp,
  output logic [PTR_W-1:0] rp,
  output logic             full,
  output logic             empty,
  output logic             dropped
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] DEP8 = PTR_W'(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [IW-1:0]    widx, ridx;
  logic [PTR_W-1:0] used;
  logic             do_push, do_pop;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  assign used    = slots_used(wp, rp);
  assign full    = (used == DEP8);
  assign empty   = (used == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dropped = push && full && !clr;
  assign head    = mem[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; widx <= '0; ridx <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; widx <= '0; ridx <= '0;
    end else begin
      if (do_push) begin
        wp   <= wp + 1'b1;
        widx <= step(widx);
      end
      if (do_pop) begin
        rp   <= rp + 1'b1;
        ridx <= step(ridx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[widx] <= push_data;
  end
endmodule

// File: rtl/mbox_flags.sv
`timescale 1ns/1ps
module mbox_flags
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_wr,
  input  logic [5:0] stat_bits,
  input  logic       doorbell,
  input  logic       eng_ack,
  input  logic       eng_ready,
  input  logic       host_drop,
  input  logic       eng_drop,
  output logic       evt_rst,
  output logic       evt_ig,
  output side_flags_t hf,
  output side_flags_t ef
);
  logic e_pend, e_rdy, e_ovf;

  assign evt_rst = stat_wr && stat_bits[B_RST];
  assign evt_ig  = stat_wr && stat_bits[B_DB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf <= '0;
    end else begin
      if (stat_wr) begin
        hf.ie  <= stat_bits[B_IE];
        hf.rdy <= stat_bits[B_RDY] && !stat_bits[B_RST];
        hf.rst <= stat_bits[B_RST];
      end
      if (doorbell)                       hf.pend <= 1'b1;
      else if (stat_wr && stat_bits[B_PND]) hf.pend <= 1'b0;
      if (evt_rst)                        hf.ovf <= 1'b0;
      else if (host_drop)                 hf.ovf <= 1'b1;
      else if (stat_wr && stat_bits[B_OVF]) hf.ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pend <= 1'b0; e_rdy <= 1'b0; e_ovf <= 1'b0;
    end else begin
      if (evt_ig)       e_pend <= 1'b1;
      else if (eng_ack) e_pend <= 1'b0;
      if (evt_rst)        e_rdy <= 1'b0;
      else if (eng_ready) e_rdy <= 1'b1;
      if (evt_rst)       e_ovf <= 1'b0;
      else if (eng_drop) e_ovf <= 1'b1;
    end
  end

  always_comb begin
    ef.ie   = 1'b0;
    ef.pend = e_pend;
    ef.rdy  = e_rdy;
    ef.rst  = hf.rst;
    ef.ovf  = e_ovf;
  end
endmodule

// File: rtl/ring_mailbox.sv
`timescale 1ns/1ps
module ring_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_irq,
  input  logic        eng_push,
  input  logic [31:0] eng_wdata,
  input  logic        eng_pop,
  output logic [31:0] eng_rdata,
  input  logic        eng_doorbell,
  input  logic        eng_is_clr,
  input  logic        eng_set_ready,
  output logic [7:0]  eng_rx_count,
  output logic [7:0]  eng_tx_space,
  output logic        eng_irq,
  output logic        eng_rst_req
);
  localparam logic [PTR_W-1:0] DEP8 = PTR_W'(DEPTH);

  // named internal events
  logic evt_hwin_wr, evt_hwin_rd, evt_stat_wr, evt_rst, evt_ig;
  logic [PTR_W-1:0] h2e_wp, h2e_rp, e2h_wp, e2h_rp;
  logic h2e_full, h2e_empty, h2e_drop;
  logic e2h_full, e2h_empty, e2h_drop;
  logic [DATA_W-1:0] e2h_head;
  logic [DATA_W-1:0] rd_mux;
  side_flags_t hf, ef;

  assign evt_hwin_wr = host_wr && (host_addr == OFS_TXWIN);
  assign evt_stat_wr = host_wr && (host_addr == OFS_HSTAT);
  assign evt_hwin_rd = host_rd && (host_addr == OFS_RXWIN);

  mbox_ring #(.DEPTH(DEPTH), .W(DATA_W)) u_h2e (
    .clk(clk), .rst_n(rst_n), .clr(evt_rst),
    .push(evt_hwin_wr), .push_data(host_wdata), .pop(eng_pop),
    .head(eng_rdata), .wp(h2e_wp), .rp(h2e_rp),
    .full(h2e_full), .empty(h2e_empty), .dropped(h2e_drop)
  );

  mbox_ring #(.DEPTH(DEPTH), .W(DATA_W)) u_e2h (
    .clk(clk), .rst_n(rst_n), .clr(evt_rst),
    .push(eng_push), .push_data(eng_wdata), .pop(evt_hwin_rd),
    .head(e2h_head), .wp(e2h_wp), .rp(e2h_rp),
    .full(e2h_full), .empty(e2h_empty), .dropped(e2h_drop)
  );

  mbox_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .stat_wr(evt_stat_wr), .stat_bits(host_wdata[5:0]),
    .doorbell(eng_doorbell), .eng_ack(eng_is_clr), .eng_ready(eng_set_ready),
    .host_drop(h2e_drop), .eng_drop(e2h_drop),
    .evt_rst(evt_rst), .evt_ig(evt_ig), .hf(hf), .ef(ef)
  );

  always_comb begin
    case (host_addr)
      OFS_HSTAT: rd_mux = pack_status(hf, h2e_rp, h2e_wp, DEP8);
      OFS_RXWIN: rd_mux = e2h_empty ? '0 : e2h_head;
      OFS_ESTAT: rd_mux = pack_status(ef, e2h_rp, e2h_wp, DEP8);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  assign host_irq     = hf.ie && hf.pend;
  assign eng_irq      = ef.pend;
  assign eng_rst_req  = hf.rst;
  assign eng_rx_count = slots_used(h2e_wp, h2e_rp);
  assign eng_tx_space = slots_free(DEP8, e2h_wp, e2h_rp);
endmodule

// File: rtl/mbox_chk.sv
`timescale 1ns/1ps
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_rst,
  input logic             evt_ig,
  input logic             evt_hwin_wr,
  input logic             evt_hwin_rd,
  input logic [PTR_W-1:0] h2e_wp,
  input logic [PTR_W-1:0] h2e_rp,
  input logic [PTR_W-1:0] e2h_wp,
  input logic [PTR_W-1:0] e2h_rp,
  input logic             h2e_full,
  input logic             e2h_empty,
  input logic             host_ovf,
  input logic             host_pend,
  input logic             host_rdy,
  input logic             eng_rdy,
  input logic             eng_irq,
  input logic             eng_doorbell,
  input logic [31:0]      host_rdata
);
  localparam logic [PTR_W-1:0] DEP8 = PTR_W'(DEPTH);

  AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hwin_wr && !h2e_full |=> h2e_wp == $past(h2e_wp) + 8'd1); // R2
  AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slots_used(h2e_wp, h2e_rp) <= DEP8 && slots_used(e2h_wp, e2h_rp) <= DEP8); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hwin_wr && h2e_full |=> $stable(h2e_wp) && host_ovf); // R4
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hwin_rd && e2h_empty |=> host_rdata == 32'd0 && $stable(e2h_rp)); // R5
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_doorbell |=> host_pend); // R6
  AST_DOORBELL_ENG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ig |=> eng_irq); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rst |=> h2e_wp == 8'd0 && h2e_rp == 8'd0 && e2h_wp == 8'd0
                && e2h_rp == 8'd0 && !host_ovf); // R9
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rst |=> !eng_rdy && !host_rdy); // R10
endmodule

bind ring_mailbox mbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_rst(evt_rst), .evt_ig(evt_ig),
  .evt_hwin_wr(evt_hwin_wr), .evt_hwin_rd(evt_hwin_rd),
  .h2e_wp(h2e_wp), .h2e_rp(h2e_rp), .e2h_wp(e2h_wp), .e2h_rp(e2h_rp),
  .h2e_full(h2e_full), .e2h_empty(e2h_empty),
  .host_ovf(hf.ovf), .host_pend(hf.pend), .host_rdy(hf.rdy), .eng_rdy(ef.rdy),
  .eng_irq(eng_irq), .eng_doorbell(eng_doorbell), .host_rdata(host_rdata)
);

// File: tb/ring_mailbox_tb.sv
`timescale 1ns/1ps
module ring_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        eng_push = 1'b0, eng_pop = 1'b0;
  logic [31:0] eng_wdata = '0;
  logic [31:0] eng_rdata;
  logic        eng_doorbell = 1'b0, eng_is_clr = 1'b0, eng_set_ready = 1'b0;
  logic [7:0]  eng_rx_count, eng_tx_space;
  logic        eng_irq, eng_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ring_mailbox #(.DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .eng_pop(eng_pop), .eng_rdata(eng_rdata), .eng_doorbell(eng_doorbell),
    .eng_is_clr(eng_is_clr), .eng_set_ready(eng_set_ready),
    .eng_rx_count(eng_rx_count), .eng_tx_space(eng_tx_space),
    .eng_irq(eng_irq), .eng_rst_req(eng_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic epush(input logic [31:0] d);
    eng_push = 1'b1; eng_wdata = d;
    @(negedge clk);
    eng_push = 1'b0;
  endtask

  task automatic epop_chk(input string tag, input logic [31:0] exp);
    chk(tag, eng_rdata, exp);
    eng_pop = 1'b1;
    @(negedge clk);
    eng_pop = 1'b0;
  endtask

  task automatic pulse_db();
    eng_doorbell = 1'b1; @(negedge clk); eng_doorbell = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    hread(4'h4, d); chk("R1 host status after reset", d, 32'h0800_0000);
    hread(4'hC, d); chk("R1 engine status after reset", d, 32'h0800_0000);
    chk("R7 irq after reset", {31'd0, host_irq}, 32'd0);
    chk("R3 rx count after reset", {24'd0, eng_rx_count}, 32'd0);
    chk("R3 tx space after reset", {24'd0, eng_tx_space}, 32'd8);
    chk("R9 rst_req after reset", {31'd0, eng_rst_req}, 32'd0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    hwrite(4'h0, 32'h11); hwrite(4'h0, 32'h22); hwrite(4'h0, 32'h33);
    hread(4'h4, d); chk("R2 wp after three writes", d, 32'h0803_0000);
    chk("R3 rx count three", {24'd0, eng_rx_count}, 32'd3);
    epop_chk("R2 order 1", 32'h11);
    epop_chk("R2 order 2", 32'h22);
    epop_chk("R2 order 3", 32'h33);
    hread(4'h4, d); chk("R2 rp after pops", d, 32'h0803_0300);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) hwrite(4'h0, 32'h100 + i);
    chk("R3 rx count full", {24'd0, eng_rx_count}, 32'd8);
    hwrite(4'h0, 32'hDEAD);
    hread(4'h4, d); chk("R4 drop keeps wp, sets ovf", d, 32'h080B_0320);
    chk("R4 rx count after drop", {24'd0, eng_rx_count}, 32'd8);
    for (int i = 0; i < 8; i++) epop_chk("R4 drained word", 32'h100 + i);
    hwrite(4'h4, 32'h20);
    hread(4'h4, d); chk("R4 ovf cleared by write-1", d, 32'h080B_0B00);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    for (int i = 0; i < 300; i++) begin
      hwrite(4'h0, 32'h5000 + i);
      chk("R3 wrap data", eng_rdata, 32'h5000 + i);
      eng_pop = 1'b1; @(negedge clk); eng_pop = 1'b0;
    end
    hwrite(4'h0, 32'hA); hwrite(4'h0, 32'hB);
    hread(4'h4, d); chk("R3 pointers after wrap", d, 32'h0839_3700);
    chk("R3 rx count across wrap", {24'd0, eng_rx_count}, 32'd2);
    epop_chk("R3 wrap tail 1", 32'hA);
    epop_chk("R3 wrap tail 2", 32'hB);
  endtask

  task automatic t_e2h();
    logic [31:0] d;
    epush(32'hA1); epush(32'hA2);
    chk("R3 tx space two", {24'd0, eng_tx_space}, 32'd6);
    hread(4'hC, d); chk("R1 engine status wp", d, 32'h0802_0000);
    hread(4'h8, d); chk("R5 read first", d, 32'hA1);
    hread(4'h8, d); chk("R5 read second", d, 32'hA2);
    hread(4'h8, d); chk("R5 empty read zero", d, 32'h0);
    hread(4'hC, d); chk("R5 empty read keeps rp", d, 32'h0802_0200);
    for (int i = 0; i < 9; i++) epush(32'hB0 + i);
    hread(4'hC, d); chk("R12 engine drop and ovf", d, 32'h080A_0220);
    chk("R12 tx space zero", {24'd0, eng_tx_space}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      hread(4'h8, d); chk("R5 drain order", d, 32'hB0 + i);
    end
    hread(4'h8, d); chk("R5 empty after drain", d, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    hwrite(4'h4, 32'h01);
    chk("R7 irq low with enable only", {31'd0, host_irq}, 32'd0);
    pulse_db();
    hread(4'h4, d); chk("R6 doorbell sets pending", d, 32'h0839_3903);
    chk("R7 irq high", {31'd0, host_irq}, 32'd1);
    hwrite(4'h4, 32'h01);
    hread(4'h4, d); chk("R6 write 0 keeps pending", d, 32'h0839_3903);
    hwrite(4'h4, 32'h03);
    hread(4'h4, d); chk("R6 write 1 clears pending", d, 32'h0839_3901);
    chk("R7 irq low after clear", {31'd0, host_irq}, 32'd0);
    host_wr = 1'b1; host_addr = 4'h4; host_wdata = 32'h03; eng_doorbell = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; eng_doorbell = 1'b0;
    hread(4'h4, d); chk("R6 set wins over clear", d, 32'h0839_3903);
    hwrite(4'h4, 32'h02);
    pulse_db();
    chk("R7 irq masked by enable", {31'd0, host_irq}, 32'd0);
    hwrite(4'h4, 32'h02);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    hwrite(4'h4, 32'h04);
    chk("R8 eng_irq after doorbell", {31'd0, eng_irq}, 32'd1);
    hread(4'h4, d); chk("R8 doorbell bit reads 0", d, 32'h0839_3900);
    hread(4'hC, d); chk("R8 engine pending visible", d, 32'h080A_0A22);
    eng_is_clr = 1'b1; @(negedge clk); eng_is_clr = 1'b0;
    chk("R8 eng_irq cleared", {31'd0, eng_irq}, 32'd0);
  endtask

  task automatic t_handshake();
    logic [31:0] d;
    eng_set_ready = 1'b1; @(negedge clk); eng_set_ready = 1'b0;
    hread(4'hC, d); chk("R10 engine ready visible", d, 32'h080A_0A28);
    hwrite(4'h4, 32'h08);
    hread(4'h4, d); chk("R10 host ready", d, 32'h0839_3908);
    hwrite(4'h0, 32'h77); epush(32'h88);
    hwrite(4'h4, 32'h14);
    hread(4'h4, d); chk("R9 host status after reset request", d, 32'h0800_0010);
    hread(4'hC, d); chk("R9 engine status after reset request", d, 32'h0800_0012);
    chk("R9 rst_req high", {31'd0, eng_rst_req}, 32'd1);
    chk("R9 rx count cleared", {24'd0, eng_rx_count}, 32'd0);
    chk("R9 tx space restored", {24'd0, eng_tx_space}, 32'd8);
    hread(4'h8, d); chk("R9 engine ring emptied", d, 32'h0);
    eng_set_ready = 1'b1; @(negedge clk); eng_set_ready = 1'b0;
    hread(4'hC, d); chk("R10 engine ready during reset", d, 32'h0800_001A);
    hwrite(4'h4, 32'h0C);
    hread(4'h4, d); chk("R10 host leaves reset ready", d, 32'h0800_0008);
    chk("R9 rst_req released", {31'd0, eng_rst_req}, 32'd0);
    eng_is_clr = 1'b1; @(negedge clk); eng_is_clr = 1'b0;
    host_wr = 1'b1; host_addr = 4'h4; host_wdata = 32'h10; eng_set_ready = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; eng_set_ready = 1'b0;
    hread(4'hC, d); chk("R10 reset wins over ready", d, 32'h0800_0010);
    hwrite(4'h4, 32'h08);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    hread(4'h2, d); chk("R11 unmapped read zero", d, 32'h0);
    hwrite(4'h1, 32'hFF);
    hread(4'h4, d); chk("R11 unmapped write ignored", d, 32'h0800_0008);
    chk("R11 rx count unchanged", {24'd0, eng_rx_count}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_order();
    t_full();
    t_wrap();
    t_e2h();
    t_pending();
    t_doorbell();
    t_handshake();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule